// File: doc/BRIEF.md
# SDRAM Burst-2 Memory Responder

This block answers SDRAM-style commands the way a small memory device would, so that a controller can be exercised in a testbench or looped back on silicon without an external memory model. It decodes activate, read and write commands from active-low select, row-strobe, column-strobe and write-enable pins. It keeps one open row per bank. From the open row, the bank and the column it forms a linear word address. Writes store a two-word burst. Reads return a two-word burst after a fixed latency.

The data bus is 16 bits wide. There are four banks, 13-bit rows and 9-bit columns. The storage array is much smaller than that address space: its depth is a parameter, and the formed address keeps only its low bits. Read data passes through a circular result queue whose pointer advances every clock. Each slot is cleared once it has been presented, so any clock without read data yields zero. While the host drives the bus, the data output simply mirrors the write data. A sticky flag records any command issued with the wrong bus direction.

Top module: `sdram_burst_resp`

## Requirements
- R1: After reset, with the host-drive input low, the data output is 0 and the direction-error flag is 0.
- R2: An activate (select low, row strobe low, column strobe high, write enable high) records the 13-bit address bus as the open row of the bank on the bank inputs. It leaves every other bank's open row unchanged.
- R3: The linear word address is the concatenation {open row of the selected bank, bank, address bits 8:0}, truncated to its low log2(MEM_WORDS) bits. With the default 4096 words, only row bit 0 takes part.
- R4: A write (select low, row strobe high, column strobe low, write enable low) stores the data-bus word at the linear address on the command clock.
- R5: The data-bus word of the clock after a write command is stored at linear address + 1, which wraps within the array.
- R6: A read (select low, row strobe high, column strobe low, write enable high) presents the word at the linear address on the output during the third clock after the command. It presents the word at address + 1 during the fourth clock, and the output is not yet driven with read data in the second clock.
- R7: A queue slot reads as zero after it has been presented, so clocks that carry no read data give an output of 0.
- R8: While the host-drive input is high, the data output equals the write-data input in the same clock.
- R9: A write issued with host-drive low, or a read issued with host-drive high, sets the direction-error flag. The flag stays set until reset.
- R10: Any pin pattern with select high is ignored and changes neither memory nor the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| bank_i | input | 2 | Bank select |
| addr_i | input | 13 | Row address on activate; column in bits 8:0 on read/write |
| host_drv_i | input | 1 | High while the host drives the data bus |
| wdata_i | input | 16 | Write data from the host |
| rdata_o | output | 16 | Read data, or the echoed write data while the host drives |
| dir_err_o | output | 1 | Sticky bus-direction error |

## Verification
Each result has a fixed due time. Counting from the clock edge that samples a command, an activated row or a first write word is in place after that same edge. The second write word lands on the following edge. Read words appear after the third and fourth edges, and the output is zero again after the fifth. The bench changes inputs on falling edges and counts falling edges from the command edge, so it reads each read word in the exact clock it is due. It also checks that the output is still zero one clock earlier and returns to zero one clock later. The echo and the error flag are checked in the clock of the driving stimulus and again on later clocks, which covers both the immediate and the sticky behaviour.

// File: rtl/sdr_resp_pkg.sv
package sdr_resp_pkg;
  localparam int DATA_W = 16;
  localparam int ROW_W  = 13;
  localparam int BANK_W = 2;
  localparam int COL_W  = 9;
  localparam int NBANKS = 1 << BANK_W;
  localparam int LIN_W  = ROW_W + BANK_W + COL_W;

  typedef enum logic [1:0] {CMD_NOP, CMD_ACT, CMD_RD, CMD_WR} cmd_e;
endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_resp_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);
  always_comb begin
    cmd_o = CMD_NOP;
    if (!cs_ni) begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdr_row_table.sv
module sdr_row_table
  import sdr_resp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  addr_i,
  output logic [ROW_W-1:0]  row_o
);
  logic [ROW_W-1:0] row_q [NBANKS];

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) row_q[b] <= '0;
      else if (act_i && bank_i == BANK_W'(b)) row_q[b] <= addr_i;
    end
  end

  assign row_o = row_q[bank_i];

  AST_OTHER_ROW_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && bank_i != '0) |=> $stable(row_q[0])); // R2
endmodule

// File: rtl/sdr_word_store.sv
module sdr_word_store
  import sdr_resp_pkg::*;
#(
  parameter int MEM_WORDS = 4096,
  localparam int AW = $clog2(MEM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] word_a_o,
  output logic [DATA_W-1:0] word_b_o
);
  logic [DATA_W-1:0] mem_q [MEM_WORDS];
  logic              pend_q;
  logic [AW-1:0]     pend_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
    end else begin
      pend_q      <= wr_i;
      pend_addr_q <= addr_i + AW'(1);
    end
  end

  // Second burst word first, so a fresh write on the same edge wins.
  always_ff @(posedge clk_i) begin
    if (pend_q) mem_q[pend_addr_q] <= wdata_i;
    if (wr_i)   mem_q[addr_i]      <= wdata_i;
  end

  assign word_a_o = mem_q[addr_i];
  assign word_b_o = mem_q[addr_i + AW'(1)];

  AST_SECOND_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |=> mem_q[$past(pend_addr_q)] == $past(wdata_i)); // R5
endmodule

// File: rtl/sdr_read_queue.sv
module sdr_read_queue
  import sdr_resp_pkg::*;
#(
  parameter int QDEPTH = 8,
  parameter int LAT    = 3,
  localparam int QW    = $clog2(QDEPTH),
  localparam int IDLE_W = QW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] word_a_i,
  input  logic [DATA_W-1:0] word_b_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] slot_q [QDEPTH];
  logic [QW-1:0]     ptr_q;
  logic [DATA_W-1:0] rdata_q;
  logic [IDLE_W-1:0] idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < QDEPTH; i++) slot_q[i] <= '0;
      ptr_q   <= '0;
      rdata_q <= '0;
    end else begin
      rdata_q <= slot_q[ptr_q + QW'(1)];
      slot_q[ptr_q + QW'(1)] <= '0;
      ptr_q <= ptr_q + QW'(1);
      if (rd_i) begin
        slot_q[ptr_q + QW'(LAT + 1)] <= word_a_i;
        slot_q[ptr_q + QW'(LAT + 2)] <= word_b_i;
      end
    end
  end

  // Clocks since the last read, saturating; used only by the check below.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    idle_q <= '1;
    else if (rd_i)                  idle_q <= '0;
    else if (idle_q != '1)          idle_q <= idle_q + IDLE_W'(1);
  end

  assign rdata_o = rdata_q;

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_q >= IDLE_W'(LAT + 2)) |-> rdata_q == '0); // R7
endmodule

// File: rtl/sdram_burst_resp.sv
module sdram_burst_resp
  import sdr_resp_pkg::*;
#(
  parameter int MEM_WORDS = 4096,
  parameter int QDEPTH    = 8,
  localparam int AW = $clog2(MEM_WORDS)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cs_ni,
  input  logic        ras_ni,
  input  logic        cas_ni,
  input  logic        we_ni,
  input  logic [1:0]  bank_i,
  input  logic [12:0] addr_i,
  input  logic        host_drv_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        dir_err_o
);
  cmd_e              cmd;
  logic              act, rd, wr;
  logic [ROW_W-1:0]  open_row;
  logic [LIN_W-1:0]  lin_full;
  logic [AW-1:0]     lin_addr;
  logic [DATA_W-1:0] word_a, word_b, q_data;
  logic              dir_err_q;
  logic              unused_hi;

  sdr_cmd_decode u_dec (
    .cs_ni(cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni), .cmd_o(cmd)
  );

  assign act = (cmd == CMD_ACT);
  assign rd  = (cmd == CMD_RD);
  assign wr  = (cmd == CMD_WR);

  sdr_row_table u_rows (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_i(act), .bank_i(bank_i),
    .addr_i(addr_i), .row_o(open_row)
  );

  assign lin_full  = {open_row, bank_i, addr_i[COL_W-1:0]};
  assign lin_addr  = lin_full[AW-1:0];
  assign unused_hi = ^lin_full;

  sdr_word_store #(.MEM_WORDS(MEM_WORDS)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .addr_i(lin_addr),
    .wdata_i(wdata_i), .word_a_o(word_a), .word_b_o(word_b)
  );

  sdr_read_queue #(.QDEPTH(QDEPTH), .LAT(3)) u_queue (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd), .word_a_i(word_a),
    .word_b_i(word_b), .rdata_o(q_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dir_err_q <= 1'b0;
    else if ((wr && !host_drv_i) || (rd && host_drv_i)) dir_err_q <= 1'b1;
  end

  assign dir_err_o = dir_err_q;
  assign rdata_o   = host_drv_i ? wdata_i : q_data;

  AST_DIR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_err_o |=> dir_err_o); // R9
  AST_DESEL_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && !dir_err_o) |=> !dir_err_o); // R10
endmodule

// File: tb/sdram_burst_resp_tb_top.sv
`timescale 1ns/1ps
module sdram_burst_resp_tb_top;
  localparam time CLK_P = 8ns;
  localparam logic [3:0] P_ACT = 4'b0011, P_RD = 4'b0101, P_WR = 4'b0100,
                         P_NOP = 4'b0111, P_DESEL_WR = 4'b1100;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  bank = '0;
  logic [12:0] addr = '0;
  logic        drv = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        dir_err;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sdram_burst_resp dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .bank_i(bank), .addr_i(addr), .host_drv_i(drv),
    .wdata_i(wdata), .rdata_o(rdata), .dir_err_o(dir_err)
  );

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic pins(logic [3:0] p);
    {cs_n, ras_n, cas_n, we_n} = p;
  endtask

  // Called at a falling edge; returns at the falling edge after the command edge.
  task automatic issue(logic [3:0] p, logic [1:0] b, logic [12:0] a, logic d, logic [15:0] w);
    pins(p); bank = b; addr = a; drv = d; wdata = w;
    @(negedge clk);
    pins(P_NOP);
  endtask

  task automatic do_act(logic [1:0] b, logic [12:0] row);
    issue(P_ACT, b, row, 1'b0, 16'h0);
  endtask

  task automatic do_write(logic [1:0] b, logic [8:0] col, logic [15:0] d0, logic [15:0] d1);
    issue(P_WR, b, {4'b0, col}, 1'b1, d0);
    wdata = d1;
    #1 check("R8 echo", rdata, d1);
    @(negedge clk);
    drv = 1'b0; wdata = '0;
  endtask

  task automatic do_read(string req, logic [1:0] b, logic [8:0] col,
                         logic [15:0] ea, logic [15:0] eb, bit chk_b);
    issue(P_RD, b, {4'b0, col}, 1'b0, 16'h0);
    @(negedge clk); @(negedge clk);
    check("R6 not early", rdata, 16'h0);
    @(negedge clk);
    check({req, " word0"}, rdata, ea);
    @(negedge clk);
    if (chk_b) check({req, " word1"}, rdata, eb);
    @(negedge clk);
    check("R7 idle zero", rdata, 16'h0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 rdata", rdata, 16'h0);
    check("R1 dir_err", {15'b0, dir_err}, 16'h0);
  endtask

  task automatic t_basic;
    do_act(2'd0, 13'd0);
    do_write(2'd0, 9'd10, 16'h1111, 16'h2222);
    do_read("R4 R5 R6 basic", 2'd0, 9'd10, 16'h1111, 16'h2222, 1'b1);
  endtask

  task automatic t_banks;
    do_act(2'd1, 13'd1);
    do_write(2'd1, 9'd10, 16'hAAAA, 16'hBBBB);
    do_act(2'd2, 13'd0);
    do_write(2'd2, 9'd10, 16'hCCCC, 16'hDDDD);
    do_read("R3 bank0", 2'd0, 9'd10, 16'h1111, 16'h2222, 1'b1);
    do_read("R3 bank1", 2'd1, 9'd10, 16'hAAAA, 16'hBBBB, 1'b1);
    do_read("R3 bank2", 2'd2, 9'd10, 16'hCCCC, 16'hDDDD, 1'b1);
    do_act(2'd1, 13'd3); // upper row bits fall outside the array
    do_read("R3 truncated row", 2'd1, 9'd10, 16'hAAAA, 16'hBBBB, 1'b1);
    do_read("R2 other bank kept", 2'd0, 9'd10, 16'h1111, 16'h2222, 1'b1);
  endtask

  task automatic t_reopen;
    do_act(2'd0, 13'd1);
    do_write(2'd0, 9'd10, 16'hEEEE, 16'hFFFF);
    do_read("R2 new row", 2'd0, 9'd10, 16'hEEEE, 16'hFFFF, 1'b1);
    do_act(2'd0, 13'd0);
    do_read("R2 row switched back", 2'd0, 9'd10, 16'h1111, 16'h2222, 1'b1);
  endtask

  task automatic t_wrap;
    do_act(2'd3, 13'd1);
    do_write(2'd3, 9'd511, 16'h1234, 16'h5678);
    do_read("R5 wrap top", 2'd3, 9'd511, 16'h1234, 16'h5678, 1'b1);
    do_read("R5 wrap to zero", 2'd0, 9'd0, 16'h5678, 16'h0, 1'b0);
  endtask

  task automatic t_deselect;
    issue(P_DESEL_WR, 2'd0, 13'd10, 1'b0, 16'h9999);
    @(negedge clk);
    do_read("R10 deselect ignored", 2'd0, 9'd10, 16'h1111, 16'h2222, 1'b1);
    check("R10 no error", {15'b0, dir_err}, 16'h0);
  endtask

  task automatic t_echo;
    drv = 1'b1; wdata = 16'h0F0F;
    #1 check("R8 echo idle", rdata, 16'h0F0F);
    @(negedge clk);
    wdata = 16'hF00F;
    #1 check("R8 echo follows", rdata, 16'hF00F);
    drv = 1'b0; wdata = '0;
    #1 check("R7 output after echo", rdata, 16'h0);
    @(negedge clk);
  endtask

  task automatic t_dir_err;
    check("R9 clear before", {15'b0, dir_err}, 16'h0);
    issue(P_WR, 2'd2, 13'd20, 1'b0, 16'h4444);
    check("R9 set by write without drive", {15'b0, dir_err}, 16'h1);
    repeat (4) @(negedge clk);
    check("R9 sticky", {15'b0, dir_err}, 16'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_banks();
    t_reopen();
    t_wrap();
    t_deselect();
    t_echo();
    t_dir_err();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule